// File: doc/BRIEF.md
# PHY Bring-up and Autonegotiation Sequencer

This block drives an attached Ethernet PHY from power-up to a resolved link configuration with no software involvement. It issues register reads and writes through a management-frame engine, one request at a time. First it scans the management addresses for a PHY with a plausible identifier. Then it resets that PHY, masks its event sources and advertises the abilities the PHY reports. Last it starts autonegotiation, polls until negotiation completes and commits the speed and duplex settings.

A single `start_i` pulse launches the run. When the run ends, `done_o` rises and stays high together with the result outputs until the next start. If the run fails, exactly one error flag is set: no PHY found, reset timeout or negotiation timeout. The wait between polls is a cycle-count parameter, so fast test runs can use short delays.

Top module: `phy_bringup_seq`

## Requirements
- R1: Addresses 0 to 31 are visited in ascending order. At each address register 2 is read and then register 3.
- R2: An address is accepted when both identifier words are neither 0x0000, 0xFFFF nor 0x8000. The first accepted address ends the scan and appears on `phy_addr_o`.
- R3: If address 31 is rejected, `err_no_phy_o` and `done_o` are set and no further access is issued.
- R4: The sequencer writes 0x8000 to register 0, then reads register 0 up to RST_POLLS (6) times, waiting WAIT_CYCLES between reads, until bit 15 reads 0. If bit 15 is still 1 on the last read, `err_rst_to_o` is set and the run ends.
- R5: After reset, register 18 is read once, then register 19 is written with 0xFF00 (eight event-mask bits).
- R6: Register 1 is read, and register 4 is written with 0x0001 plus status bits 15,14,13,12,11 copied to bits 9,8,7,6,5.
- R7: Register 0 is written with 0x1200, then register 1 is read up to AN_POLLS (20) times with WAIT_CYCLES between reads, until bit 5 reads 1.
- R8: An incomplete poll that shows bit 4 (remote fault) set is followed, after the wait, by a write of 0x3300 to register 0 before the next poll. No restart follows the final poll.
- R9: If no poll sees bit 5 set, `err_aneg_to_o` is set, and speed and duplex are still committed.
- R10: `speed_o` equals bit 7 and `duplex_o` equals bit 6 of the register-18 value read in R5.
- R11: While a run is in progress, `done_o`, `speed_o`, `duplex_o` and all error flags are 0. After the run they hold until the next `start_i`.
- R12: A management request keeps its write flag, address, register and write data unchanged until `mgmt_done_i`. Read data is taken in the `mgmt_done_i` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a bring-up run (accepted when idle or done) |
| mgmt_req_o | output | 1 | Management access request |
| mgmt_wr_o | output | 1 | 1 = write, 0 = read |
| mgmt_phy_o | output | 5 | PHY address of the access |
| mgmt_reg_o | output | 5 | Register number of the access |
| mgmt_wdata_o | output | 16 | Write data |
| mgmt_done_i | input | 1 | One-cycle completion of the current access |
| mgmt_rdata_i | input | 16 | Read data, valid with mgmt_done_i |
| phy_addr_o | output | 5 | Address of the discovered PHY |
| speed_o | output | 1 | Committed speed (1 = 100 Mb/s) |
| duplex_o | output | 1 | Committed duplex (1 = full) |
| done_o | output | 1 | Run finished (result or error) |
| err_no_phy_o | output | 1 | No acceptable identifier found |
| err_rst_to_o | output | 1 | PHY reset did not clear |
| err_aneg_to_o | output | 1 | Negotiation did not complete |

## Verification
The assertions assume that the management engine raises `mgmt_done_i` only while a request is pending, and for exactly one cycle per access. They also assume `start_i` arrives only when the sequencer is idle or done. The bench PHY model acknowledges each captured request once, after a per-scenario latency of zero to three cycles, and never acknowledges without a request. Start pulses are issued only after `done_o` is seen high, or after reset.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ID1, ST_ID2, ST_RST_WR, ST_RST_RD, ST_RST_WAIT,
    ST_VSTAT, ST_MASK, ST_CAPS, ST_ADV, ST_AN_GO, ST_AN_RD,
    ST_AN_WAIT, ST_AN_FIX, ST_DONE
  } seq_state_e;

  localparam logic [4:0] REG_CTRL  = 5'd0;
  localparam logic [4:0] REG_STAT  = 5'd1;
  localparam logic [4:0] REG_ID1   = 5'd2;
  localparam logic [4:0] REG_ID2   = 5'd3;
  localparam logic [4:0] REG_ADV   = 5'd4;
  localparam logic [4:0] REG_VSTAT = 5'd18;
  localparam logic [4:0] REG_IMASK = 5'd19;

  localparam logic [15:0] CTRL_RESET  = 16'h8000;
  localparam logic [15:0] CTRL_AN_GO  = 16'h1200;
  localparam logic [15:0] CTRL_AN_FIX = 16'h3300;
  localparam logic [15:0] IMASK_WORD  = 16'hFF00;

  localparam int CTRL_RST_BIT  = 15;
  localparam int STAT_DONE_BIT = 5;
  localparam int STAT_RFLT_BIT = 4;
  localparam int VSTAT_SPD_BIT = 7;
  localparam int VSTAT_DPX_BIT = 6;
  localparam int CAP_LSB       = 11;
  localparam int ADV_CAP_LSB   = 5;
  localparam int NUM_CAPS      = 5;
  localparam logic [4:0] ADV_SELECTOR = 5'b00001;
endpackage

// File: rtl/phy_seq_id_check.sv
module phy_seq_id_check (
  input  logic [15:0] id_a_i,
  input  logic [15:0] id_b_i,
  output logic        ok_o
);
  function automatic logic id_good(logic [15:0] v);
    return (v != 16'h0000) && (v != 16'hFFFF) && (v != 16'h8000);
  endfunction

  assign ok_o = id_good(id_a_i) && id_good(id_b_i);
endmodule

// File: rtl/phy_seq_adv_build.sv
module phy_seq_adv_build import phy_seq_pkg::*; (
  input  logic [NUM_CAPS-1:0] caps_i,
  output logic [15:0]         adv_o
);
  for (genvar i = 0; i < NUM_CAPS; i++) begin : g_cap
    assign adv_o[ADV_CAP_LSB+i] = caps_i[i];
  end
  assign adv_o[ADV_CAP_LSB-1:0] = ADV_SELECTOR;
  assign adv_o[15:ADV_CAP_LSB+NUM_CAPS] = '0;
endmodule

// File: rtl/phy_seq_wait_timer.sv
module phy_seq_wait_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned CW = (CYCLES < 1) ? 1 : $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq import phy_seq_pkg::*; #(
  parameter int unsigned WAIT_CYCLES = 5000,
  parameter int unsigned RST_POLLS   = 6,
  parameter int unsigned AN_POLLS    = 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output logic        mgmt_req_o,
  output logic        mgmt_wr_o,
  output logic [4:0]  mgmt_phy_o,
  output logic [4:0]  mgmt_reg_o,
  output logic [15:0] mgmt_wdata_o,
  input  logic        mgmt_done_i,
  input  logic [15:0] mgmt_rdata_i,
  output logic [4:0]  phy_addr_o,
  output logic        speed_o,
  output logic        duplex_o,
  output logic        done_o,
  output logic        err_no_phy_o,
  output logic        err_rst_to_o,
  output logic        err_aneg_to_o
);
  localparam int unsigned MAXP = (RST_POLLS > AN_POLLS) ? RST_POLLS : AN_POLLS;
  localparam int unsigned PW   = $clog2(MAXP + 1);
  localparam logic [PW-1:0] RST_LAST = PW'(RST_POLLS - 1);
  localparam logic [PW-1:0] AN_LAST  = PW'(AN_POLLS - 1);

  seq_state_e    state_q;
  logic [4:0]    addr_q, found_q;
  logic [15:0]   id1_q, adv_q;
  logic [PW-1:0] poll_q;
  logic          fault_q, spd_q, dpx_q;
  logic          speed_q, duplex_q, done_q, e_nophy_q, e_rst_q, e_an_q;

  logic        id_ok, wait_load, wait_over;
  logic [15:0] adv_w;

  phy_seq_id_check u_id (.id_a_i(id1_q), .id_b_i(mgmt_rdata_i), .ok_o(id_ok));

  phy_seq_adv_build u_adv (
    .caps_i(mgmt_rdata_i[CAP_LSB+NUM_CAPS-1:CAP_LSB]),
    .adv_o (adv_w)
  );

  phy_seq_wait_timer #(.CYCLES(WAIT_CYCLES)) u_wait (
    .clk_i, .rst_ni, .load_i(wait_load), .expired_o(wait_over)
  );

  always_comb begin
    mgmt_req_o   = 1'b1;
    mgmt_wr_o    = 1'b0;
    mgmt_reg_o   = REG_CTRL;
    mgmt_wdata_o = '0;
    unique case (state_q)
      ST_ID1:    mgmt_reg_o = REG_ID1;
      ST_ID2:    mgmt_reg_o = REG_ID2;
      ST_RST_WR: begin mgmt_wr_o = 1'b1; mgmt_wdata_o = CTRL_RESET; end
      ST_RST_RD: mgmt_reg_o = REG_CTRL;
      ST_VSTAT:  mgmt_reg_o = REG_VSTAT;
      ST_MASK:   begin mgmt_wr_o = 1'b1; mgmt_reg_o = REG_IMASK; mgmt_wdata_o = IMASK_WORD; end
      ST_CAPS:   mgmt_reg_o = REG_STAT;
      ST_ADV:    begin mgmt_wr_o = 1'b1; mgmt_reg_o = REG_ADV; mgmt_wdata_o = adv_q; end
      ST_AN_GO:  begin mgmt_wr_o = 1'b1; mgmt_wdata_o = CTRL_AN_GO; end
      ST_AN_RD:  mgmt_reg_o = REG_STAT;
      ST_AN_FIX: begin mgmt_wr_o = 1'b1; mgmt_wdata_o = CTRL_AN_FIX; end
      default:   mgmt_req_o = 1'b0;
    endcase
  end
  assign mgmt_phy_o = addr_q;

  // timer is armed on the edge that enters a wait state
  always_comb begin
    wait_load = 1'b0;
    if (mgmt_done_i) begin
      if (state_q == ST_RST_RD)
        wait_load = mgmt_rdata_i[CTRL_RST_BIT] && (poll_q != RST_LAST);
      else if (state_q == ST_AN_RD)
        wait_load = !mgmt_rdata_i[STAT_DONE_BIT] && (poll_q != AN_LAST);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q <= '0; found_q <= '0; id1_q <= '0; adv_q <= '0; poll_q <= '0;
      fault_q <= 1'b0; spd_q <= 1'b0; dpx_q <= 1'b0;
      speed_q <= 1'b0; duplex_q <= 1'b0; done_q <= 1'b0;
      e_nophy_q <= 1'b0; e_rst_q <= 1'b0; e_an_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          addr_q <= '0; found_q <= '0; speed_q <= 1'b0; duplex_q <= 1'b0;
          done_q <= 1'b0; e_nophy_q <= 1'b0; e_rst_q <= 1'b0; e_an_q <= 1'b0;
          state_q <= ST_ID1;
        end
        ST_ID1: if (mgmt_done_i) begin
          id1_q   <= mgmt_rdata_i;
          state_q <= ST_ID2;
        end
        ST_ID2: if (mgmt_done_i) begin
          if (id_ok) begin
            found_q <= addr_q;
            state_q <= ST_RST_WR;
          end else if (addr_q == 5'd31) begin
            e_nophy_q <= 1'b1; done_q <= 1'b1;
            state_q   <= ST_DONE;
          end else begin
            addr_q  <= addr_q + 5'd1;
            state_q <= ST_ID1;
          end
        end
        ST_RST_WR: if (mgmt_done_i) begin
          poll_q  <= '0;
          state_q <= ST_RST_RD;
        end
        ST_RST_RD: if (mgmt_done_i) begin
          if (!mgmt_rdata_i[CTRL_RST_BIT]) state_q <= ST_VSTAT;
          else if (poll_q == RST_LAST) begin
            e_rst_q <= 1'b1; done_q <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            poll_q  <= poll_q + 1'b1;
            state_q <= ST_RST_WAIT;
          end
        end
        ST_RST_WAIT: if (wait_over) state_q <= ST_RST_RD;
        ST_VSTAT: if (mgmt_done_i) begin
          spd_q   <= mgmt_rdata_i[VSTAT_SPD_BIT];
          dpx_q   <= mgmt_rdata_i[VSTAT_DPX_BIT];
          state_q <= ST_MASK;
        end
        ST_MASK: if (mgmt_done_i) state_q <= ST_CAPS;
        ST_CAPS: if (mgmt_done_i) begin
          adv_q   <= adv_w;
          state_q <= ST_ADV;
        end
        ST_ADV: if (mgmt_done_i) state_q <= ST_AN_GO;
        ST_AN_GO: if (mgmt_done_i) begin
          poll_q  <= '0;
          state_q <= ST_AN_RD;
        end
        ST_AN_RD: if (mgmt_done_i) begin
          if (mgmt_rdata_i[STAT_DONE_BIT] || poll_q == AN_LAST) begin
            e_an_q   <= !mgmt_rdata_i[STAT_DONE_BIT];
            speed_q  <= spd_q;
            duplex_q <= dpx_q;
            done_q   <= 1'b1;
            state_q  <= ST_DONE;
          end else begin
            poll_q  <= poll_q + 1'b1;
            fault_q <= mgmt_rdata_i[STAT_RFLT_BIT];
            state_q <= ST_AN_WAIT;
          end
        end
        ST_AN_WAIT: if (wait_over) state_q <= fault_q ? ST_AN_FIX : ST_AN_RD;
        ST_AN_FIX: if (mgmt_done_i) state_q <= ST_AN_RD;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign phy_addr_o    = found_q;
  assign speed_o       = speed_q;
  assign duplex_o      = duplex_q;
  assign done_o        = done_q;
  assign err_no_phy_o  = e_nophy_q;
  assign err_rst_to_o  = e_rst_q;
  assign err_aneg_to_o = e_an_q;
endmodule

// File: rtl/phy_seq_chk.sv
module phy_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mgmt_req_o,
  input logic        mgmt_wr_o,
  input logic [4:0]  mgmt_phy_o,
  input logic [4:0]  mgmt_reg_o,
  input logic [15:0] mgmt_wdata_o,
  input logic        mgmt_done_i,
  input logic        speed_o,
  input logic        duplex_o,
  input logic        done_o,
  input logic        err_no_phy_o,
  input logic        err_rst_to_o,
  input logic        err_aneg_to_o
);
  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_req_o && !mgmt_done_i |=> mgmt_req_o && $stable(mgmt_wr_o) &&
      $stable(mgmt_phy_o) && $stable(mgmt_reg_o) && $stable(mgmt_wdata_o));

  p_one_error_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot0({err_no_phy_o, err_rst_to_o, err_aneg_to_o}));

  p_quiet_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_req_o |-> !done_o && !speed_o && !duplex_o &&
      !err_no_phy_o && !err_rst_to_o && !err_aneg_to_o);

  p_nophy_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_no_phy_o) |-> $past(mgmt_phy_o) == 5'd31 && $past(mgmt_reg_o) == 5'd3);

  p_ctrl_words_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_req_o && mgmt_wr_o && mgmt_reg_o == 5'd0 |->
      mgmt_wdata_o == 16'h8000 || mgmt_wdata_o == 16'h1200 || mgmt_wdata_o == 16'h3300);

  p_mask_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_req_o && mgmt_wr_o && mgmt_reg_o == 5'd19 |-> mgmt_wdata_o == 16'hFF00);

  p_adv_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_req_o && mgmt_wr_o && mgmt_reg_o == 5'd4 |->
      mgmt_wdata_o[4:0] == 5'b00001 && mgmt_wdata_o[15:10] == 6'd0);
endmodule

bind phy_bringup_seq phy_seq_chk u_phy_seq_chk (.*);

// File: tb/phy_bringup_seq_tb_top.sv
module phy_bringup_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WAITC      = 4;

  logic clk, rst_n, start;
  logic mreq, mwr, m_done;
  logic [4:0] mphy, mreg, paddr;
  logic [15:0] mwdata, m_rdata;
  logic spd, dpx, done, e_np, e_rs, e_an;

  phy_bringup_seq #(.WAIT_CYCLES(WAITC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mgmt_req_o(mreq), .mgmt_wr_o(mwr), .mgmt_phy_o(mphy), .mgmt_reg_o(mreg),
    .mgmt_wdata_o(mwdata), .mgmt_done_i(m_done), .mgmt_rdata_i(m_rdata),
    .phy_addr_o(paddr), .speed_o(spd), .duplex_o(dpx), .done_o(done),
    .err_no_phy_o(e_np), .err_rst_to_o(e_rs), .err_aneg_to_o(e_an));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // PHY register model
  logic [15:0] id1_m[32], id2_m[32];
  logic [15:0] caps_m, vstat_m;
  int rst_busy, an_busy, fault_poll, lat;
  int rst_left, an_cnt;
  bit an_act;

  typedef struct {bit wr; int ph; int rg; int wd; string tag;} txn_t;
  txn_t exp_q[$];
  int  exp_addr;
  bit  exp_np, exp_rs, exp_an, exp_spd, exp_dpx;

  task automatic push(bit wr, int ph, int rg, int wd, string tag);
    txn_t t;
    t.wr = wr; t.ph = ph; t.rg = rg; t.wd = wd; t.tag = tag;
    exp_q.push_back(t);
  endtask

  function automatic bit id_valid(logic [15:0] v);
    return v != 16'h0000 && v != 16'hFFFF && v != 16'h8000;
  endfunction

  // behavioural expectation of the whole access sequence
  task automatic build();
    int f;
    int adv;
    exp_q.delete();
    f = -1;
    exp_np = 0; exp_rs = 0; exp_an = 0; exp_spd = 0; exp_dpx = 0; exp_addr = 0;
    for (int a = 0; a < 32; a++) begin
      push(0, a, 2, 0, "R1");
      push(0, a, 3, 0, "R1");
      if (id_valid(id1_m[a]) && id_valid(id2_m[a])) begin f = a; break; end
    end
    if (f < 0) begin exp_np = 1; return; end
    exp_addr = f;
    push(1, f, 0, 16'h8000, "R4");
    exp_rs = 1;
    for (int p = 1; p <= 6; p++) begin
      push(0, f, 0, 0, "R4");
      if (p > rst_busy) begin exp_rs = 0; break; end
    end
    if (exp_rs) return;
    push(0, f, 18, 0, "R5");
    push(1, f, 19, 16'hFF00, "R5");
    push(0, f, 1, 0, "R6");
    adv = 1;
    if (caps_m[15]) adv += 16'h0200;
    if (caps_m[14]) adv += 16'h0100;
    if (caps_m[13]) adv += 16'h0080;
    if (caps_m[12]) adv += 16'h0040;
    if (caps_m[11]) adv += 16'h0020;
    push(1, f, 4, adv, "R6");
    push(1, f, 0, 16'h1200, "R7");
    for (int p = 1; p <= 20; p++) begin
      push(0, f, 1, 0, "R7");
      if (p > an_busy) break;
      if (p == 20) begin exp_an = 1; break; end
      if (p == fault_poll) push(1, f, 0, 16'h3300, "R8");
    end
    exp_spd = vstat_m[7];
    exp_dpx = vstat_m[6];
  endtask

  bit busy;
  int cnt;
  bit c_wr;
  logic [4:0] c_ph, c_rg;
  logic [15:0] c_wd;

  task automatic serve();
    txn_t t;
    chk(mreq && mwr == c_wr && mphy == c_ph && mreg == c_rg && mwdata == c_wd,
        "R12", "request held", {5'd0, mwr, mphy, mreg, mwdata}, {5'd0, c_wr, c_ph, c_rg, c_wd});
    if (exp_q.size() == 0) begin
      chk(0, "R1", "unexpected access", {5'd0, c_wr, c_ph, c_rg, c_wd}, 0);
    end else begin
      t = exp_q.pop_front();
      chk(c_wr == t.wr && int'(c_ph) == t.ph && int'(c_rg) == t.rg && (!t.wr || int'(c_wd) == t.wd),
          t.tag, "access", {5'd0, c_wr, c_ph, c_rg, c_wd},
          {5'd0, t.wr, 5'(t.ph), 5'(t.rg), 16'(t.wd)});
    end
    m_rdata = 16'h0;
    if (c_wr) begin
      if (c_rg == 5'd0 && c_wd[15]) rst_left = rst_busy;
      if (c_rg == 5'd0 && c_wd[12]) an_act = 1;
    end else begin
      case (c_rg)
        5'd2: m_rdata = id1_m[c_ph];
        5'd3: m_rdata = id2_m[c_ph];
        5'd0: if (rst_left > 0) begin rst_left--; m_rdata = 16'h8000; end
        5'd18: m_rdata = vstat_m;
        5'd1: begin
          m_rdata = caps_m;
          if (an_act) begin
            an_cnt++;
            if (an_cnt > an_busy) m_rdata[5] = 1'b1;
            if (an_cnt == fault_poll) m_rdata[4] = 1'b1;
          end
        end
        default: m_rdata = 16'h0;
      endcase
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      busy = 0; m_done = 0; cnt = 0;
    end else begin
      if (m_done) m_done = 0;
      if (busy) begin
        if (cnt == 0) begin serve(); m_done = 1; busy = 0; end
        else cnt--;
      end else if (mreq) begin
        busy = 1; cnt = lat;
        c_wr = mwr; c_ph = mphy; c_rg = mreg; c_wd = mwdata;
      end
    end
  end

  task automatic clear_model();
    for (int a = 0; a < 32; a++) begin id1_m[a] = 16'hFFFF; id2_m[a] = 16'hFFFF; end
    caps_m = 0; vstat_m = 0; rst_busy = 0; an_busy = 0; fault_poll = 0; lat = 2;
  endtask

  task automatic run_case(string name);
    int guard;
    rst_left = 0; an_cnt = 0; an_act = 0;
    build();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 20000) begin
      chk(!spd && !dpx && !e_np && !e_rs && !e_an, "R11", "quiet while running",
          {27'd0, spd, dpx, e_np, e_rs, e_an}, 0);
      @(negedge clk);
      guard++;
    end
    chk(done, "R11", {name, " done"}, done, 1);
    chk(exp_q.size() == 0, "R1", {name, " accesses left"}, exp_q.size(), 0);
    chk(e_np == exp_np, "R3", {name, " no-phy flag"}, e_np, exp_np);
    chk(e_rs == exp_rs, "R4", {name, " reset timeout"}, e_rs, exp_rs);
    chk(e_an == exp_an, "R9", {name, " aneg timeout"}, e_an, exp_an);
    chk(spd == exp_spd && dpx == exp_dpx, "R10", {name, " speed/duplex"},
        {spd, dpx}, {exp_spd, exp_dpx});
    if (!exp_np) chk(int'(paddr) == exp_addr, "R2", {name, " phy address"}, paddr, exp_addr);
    repeat (3) @(negedge clk);
    chk(done && !mreq && spd == exp_spd && dpx == exp_dpx && e_np == exp_np &&
        e_rs == exp_rs && e_an == exp_an, "R11", {name, " hold after done"},
        {done, mreq, spd, dpx}, {1'b1, 1'b0, exp_spd, exp_dpx});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; m_rdata = 16'h0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !mreq && !spd && !dpx && !e_np && !e_rs && !e_an && paddr == 5'd0,
        "R11", "reset state", {25'd0, done, mreq, spd, dpx, e_np, e_rs, e_an}, 0);

    // rejected identifiers first, first valid wins; full caps
    clear_model();
    id2_m[0] = 16'h1234;
    id1_m[1] = 16'h0000; id2_m[1] = 16'h0005;
    id1_m[2] = 16'h8000; id2_m[2] = 16'h1111;
    id1_m[3] = 16'h0016; id2_m[3] = 16'h8000;
    id1_m[4] = 16'h0016; id2_m[4] = 16'hF841;
    id1_m[5] = 16'h0282; id2_m[5] = 16'h1C51;
    caps_m = 16'hF800; vstat_m = 16'h0080; rst_busy = 2; an_busy = 3;
    run_case("R2 scan");

    // nothing valid, address 31 boundary
    clear_model();
    id1_m[31] = 16'h0001; id2_m[31] = 16'h0000; lat = 0;
    run_case("R3 nophy");

    // only address 31 valid, reset never clears
    clear_model();
    id1_m[31] = 16'h0001; id2_m[31] = 16'hFFFE; rst_busy = 6; lat = 1;
    run_case("R4 rst timeout");

    // reset clears on last poll, remote fault restart
    clear_model();
    id1_m[0] = 16'h0101; id2_m[0] = 16'h0202; rst_busy = 5;
    caps_m = 16'h5000; vstat_m = 16'h0040; an_busy = 4; fault_poll = 2; lat = 3;
    run_case("R8 fault");

    // negotiation timeout, fault on final poll causes no restart
    clear_model();
    id1_m[7] = 16'h7FFF; id2_m[7] = 16'h8001;
    caps_m = 16'hA800; vstat_m = 16'h00C0; an_busy = 25; fault_poll = 20; lat = 1;
    run_case("R9 aneg timeout");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule